// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects five interrupt requests for a small processor core and chooses one to present each cycle. One request cannot be masked, three are maskable and each has its own fixed service address, and one is maskable but gets its service address from the requesting device. The winning request is shown as a registered one-hot source code together with its address. For the device-vectored request the block raises a flag instead, and the core fetches the address itself.

Software sets up the block through one control byte. That byte sets the three mask bits, clears the pending latch of the edge-captured request, and can drive a serial output pin. A separate pair of commands sets and clears the global enable. The core reads back a status byte that holds the masks, the enable, the three pending lines and the serial input pin. When the core acknowledges the presented request, the block consumes it. The core's stack handling and the external address fetch are not part of this block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the three masks are 1 (masked), the global enable is 0, no request is presented, ser_out is 0 and stat_data reads 0x07.
- R2: The priority order, from highest to lowest, is nmi_req, vec_edge_req, vec_mid_req, vec_low_req, ext_req. irq_src is one-hot with bit 4 = nmi, bit 3 = edge, bit 2 = mid, bit 1 = low, bit 0 = ext, and it is 0 when irq_valid is low.
- R3: The service addresses are 0x0024 (nmi), 0x003C (edge), 0x0034 (mid) and 0x002C (low). An ext win sets irq_ext with irq_vector 0.
- R4: nmi_req ignores the masks and the enable. A rising edge latches it, and it is presented only while the input stays high. Its latch clears when the input goes low.
- R5: A maskable request is presented only when the global enable is 1 and, for a vectored one, its mask bit is 0.
- R6: A ctl_wr with ctl_data bit 3 = 1 loads the masks from bit 0 (low), bit 1 (mid) and bit 2 (edge). With bit 3 = 0 the masks are unchanged. Example: 0x0A masks only mid.
- R7: A ctl_wr with ctl_data bit 4 = 1 clears the edge pending latch. Bit 5 has no effect.
- R8: A ctl_wr with ctl_data bit 6 = 1 copies bit 7 to ser_out on the next edge. Otherwise ser_out holds its value.
- R9: stat_data is the registered value {ser_in, edge pending, vec_mid_req, vec_low_req, enable, mask edge, mask mid, mask low}, with bit 7 first.
- R10: vec_edge_req is captured on its rising edge and stays pending after the input falls. vec_mid_req and vec_low_req are levels and are not remembered.
- R11: An irq_ack of a presented maskable source clears the enable. An ack of edge clears its latch. An ack of nmi clears its latch, so a held-high nmi is not presented again.
- R12: ie_set sets the enable and ie_clr clears it. If both are high in the same cycle, clear wins.
- R13: Outputs appear one clock after the inputs that cause them. The cycle after an irq_ack, irq_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, edge plus level |
| vec_edge_req | input | 1 | Maskable vectored request, edge-captured |
| vec_mid_req | input | 1 | Maskable vectored request, level |
| vec_low_req | input | 1 | Maskable vectored request, level |
| ext_req | input | 1 | Maskable request with externally supplied address |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| ie_set | input | 1 | Global enable set command |
| ie_clr | input | 1 | Global enable clear command |
| irq_ack | input | 1 | Core accepts the presented request |
| ser_in | input | 1 | Serial input pin, reported in status |
| irq_valid | output | 1 | A request is presented |
| irq_src | output | 5 | One-hot winning source |
| irq_vector | output | ADDR_W | Service address of the winner |
| irq_ext | output | 1 | Winner needs an external address |
| stat_data | output | 8 | Status byte |
| ser_out | output | 1 | Serial output pin |

## Verification
The assertions check several properties on every clock cycle. The source code is one-hot. The ext winner never carries an address. A presented nmi was high on the sampling edge, and every presented maskable request had the enable set. The cycle after an acknowledge is blank. The masks and the serial pin hold when the control byte does not gate them. Other behaviour can only be shown by the bench's scenarios and by its cycle-by-cycle reference model, because it involves orderings of events. Examples are the full priority ladder under mixed traffic, a pulse on the edge input that is remembered, and a held-high nmi that is not re-presented after its acknowledge. Another is the exact status layout as masks, pending lines and the enable change.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC  = 5;
  localparam int S_NMI = 4;
  localparam int S_HI  = 3;
  localparam int S_MID = 2;
  localparam int S_LO  = 1;
  localparam int S_EXT = 0;

  // restart slots (in units of 8 bytes) for the vectored sources
  localparam int unsigned SLOT_NMI = 4;
  localparam int unsigned SLOT_HI  = 7;
  localparam int unsigned SLOT_MID = 6;
  localparam int unsigned SLOT_LO  = 5;

  // control byte: bit order is decoded by software, keep it
  typedef struct packed {
    logic       ser_bit;
    logic       ser_en;
    logic       spare;
    logic       hi_clr;
    logic       mask_en;
    logic [2:0] mask;
  } ctl_byte_t;

  // address halfway into restart slot n
  function automatic logic [31:0] half_slot_addr(input int unsigned slot);
    return 32'(slot * 8 + 4);
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture (
  input  logic clk,
  input  logic rst,
  input  logic nmi_in,
  input  logic hi_in,
  input  logic hi_clr,
  input  logic ack_nmi,
  input  logic ack_hi,
  output logic nmi_pend,
  output logic hi_pend
);
  logic nmi_q, hi_q;
  logic nmi_rise, hi_rise;

  assign nmi_rise = nmi_in & ~nmi_q;
  assign hi_rise  = hi_in  & ~hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      hi_q     <= 1'b0;
      nmi_pend <= 1'b0;
      hi_pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      hi_q  <= hi_in;
      if (!nmi_in)
        nmi_pend <= 1'b0;
      else
        nmi_pend <= nmi_rise | (nmi_pend & ~ack_nmi);
      hi_pend <= hi_rise | (hi_pend & ~hi_clr & ~ack_hi);
    end
  end

  AST_NMI_DROPS: assert property (@(posedge clk) disable iff (rst)
    !nmi_in |=> !nmi_pend); // R4
  AST_HI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (hi_clr && !hi_rise) |=> !hi_pend); // R7
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       ie_set,
  input  logic       ie_clr,
  input  logic       ack_maskable,
  output logic [2:0] mask,
  output logic       gie,
  output logic       ser_out
);
  ctl_byte_t ctl;
  logic      ctl_unused;

  assign ctl        = ctl_byte_t'(ctl_data);
  assign ctl_unused = ctl.spare | ctl.hi_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask    <= 3'b111;
      gie     <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      if (ctl_wr && ctl.mask_en) mask    <= ctl.mask;
      if (ctl_wr && ctl.ser_en)  ser_out <= ctl.ser_bit;
      if (ie_clr || ack_maskable) gie <= 1'b0;
      else if (ie_set)            gie <= 1'b1;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_data[3]) |=> $stable(mask)); // R6
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr && ctl_data[6]) |=> $stable(ser_out)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    ie_clr |=> !gie); // R12
  AST_ACK_DISABLES: assert property (@(posedge clk) disable iff (rst)
    ack_maskable |=> !gie); // R11
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req,
  input  logic              ack,
  output logic              valid,
  output logic [NSRC-1:0]   src,
  output logic [ADDR_W-1:0] vector,
  output logic              ext
);
  logic [NSRC-1:0]   win;
  logic [ADDR_W-1:0] vec_c;

  // higher index = higher priority; later iterations override
  always_comb begin
    win = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i]) win = NSRC'(1) << i;
  end

  always_comb begin
    vec_c = '0;
    if (win[S_NMI])      vec_c = ADDR_W'(half_slot_addr(SLOT_NMI));
    else if (win[S_HI])  vec_c = ADDR_W'(half_slot_addr(SLOT_HI));
    else if (win[S_MID]) vec_c = ADDR_W'(half_slot_addr(SLOT_MID));
    else if (win[S_LO])  vec_c = ADDR_W'(half_slot_addr(SLOT_LO));
  end

  always_ff @(posedge clk) begin
    if (rst || ack || !(|req)) begin
      valid  <= 1'b0;
      src    <= '0;
      vector <= '0;
      ext    <= 1'b0;
    end else begin
      valid  <= 1'b1;
      src    <= win;
      vector <= vec_c;
      ext    <= win[S_EXT];
    end
  end

  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    valid |-> $onehot(src)); // R2
  AST_IDLE_NO_SRC: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (src == '0)); // R2
  AST_EXT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    ext |-> (vector == '0)); // R3
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (rst)
    ack |=> !valid); // R13
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_req,
  input  logic              vec_edge_req,
  input  logic              vec_mid_req,
  input  logic              vec_low_req,
  input  logic              ext_req,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_data,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              irq_ack,
  input  logic              ser_in,
  output logic              irq_valid,
  output logic [NSRC-1:0]   irq_src,
  output logic [ADDR_W-1:0] irq_vector,
  output logic              irq_ext,
  output logic [7:0]        stat_data,
  output logic              ser_out
);
  logic [2:0]      mask;
  logic            gie, nmi_pend, hi_pend;
  logic            ack_nmi, ack_hi, ack_mask;
  logic [NSRC-1:0] req;

  assign ack_nmi  = irq_ack & irq_valid & irq_src[S_NMI];
  assign ack_hi   = irq_ack & irq_valid & irq_src[S_HI];
  assign ack_mask = irq_ack & irq_valid & (|irq_src[S_HI:S_EXT]);

  irq_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .nmi_in   (nmi_req),
    .hi_in    (vec_edge_req),
    .hi_clr   (ctl_wr & ctl_data[4]),
    .ack_nmi  (ack_nmi),
    .ack_hi   (ack_hi),
    .nmi_pend (nmi_pend),
    .hi_pend  (hi_pend)
  );

  irq_ctl_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .ctl_wr       (ctl_wr),
    .ctl_data     (ctl_data),
    .ie_set       (ie_set),
    .ie_clr       (ie_clr),
    .ack_maskable (ack_mask),
    .mask         (mask),
    .gie          (gie),
    .ser_out      (ser_out)
  );

  assign req[S_NMI] = nmi_pend & nmi_req;
  assign req[S_HI]  = hi_pend     & ~mask[2] & gie;
  assign req[S_MID] = vec_mid_req & ~mask[1] & gie;
  assign req[S_LO]  = vec_low_req & ~mask[0] & gie;
  assign req[S_EXT] = ext_req & gie;

  irq_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .ack    (irq_ack),
    .valid  (irq_valid),
    .src    (irq_src),
    .vector (irq_vector),
    .ext    (irq_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_data <= 8'h07;
    else     stat_data <= {ser_in, hi_pend, vec_mid_req, vec_low_req, gie, mask};
  end

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src[S_NMI]) |-> $past(nmi_req)); // R4
  AST_MASKABLE_GATED: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_src[S_NMI]) |-> $past(gie)); // R5
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req = 0, vec_edge_req = 0, vec_mid_req = 0, vec_low_req = 0, ext_req = 0;
  logic        ctl_wr = 0, ie_set = 0, ie_clr = 0, irq_ack = 0, ser_in = 0;
  logic [7:0]  ctl_data = 0;
  logic        irq_valid, irq_ext, ser_out;
  logic [4:0]  irq_src;
  logic [15:0] irq_vector;
  logic [7:0]  stat_data;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .vec_edge_req(vec_edge_req),
    .vec_mid_req(vec_mid_req), .vec_low_req(vec_low_req), .ext_req(ext_req),
    .ctl_wr(ctl_wr), .ctl_data(ctl_data), .ie_set(ie_set), .ie_clr(ie_clr),
    .irq_ack(irq_ack), .ser_in(ser_in), .irq_valid(irq_valid), .irq_src(irq_src),
    .irq_vector(irq_vector), .irq_ext(irq_ext), .stat_data(stat_data), .ser_out(ser_out)
  );

  // behavioural reference model
  bit [2:0]  m_mask;
  bit        m_gie, m_ser, m_hi_pend, m_hi_q, m_nmi_pend, m_nmi_q;
  bit        e_valid, e_ext;
  bit [4:0]  e_src;
  bit [15:0] e_vec;
  bit [7:0]  e_stat;

  always @(posedge clk) begin
    bit r_nmi, r_hi, r_mid, r_lo, r_ex, a_nmi, a_hi, a_m, edge_hi, edge_nmi;
    if (rst) begin
      m_mask = 3'b111; m_gie = 0; m_ser = 0; m_hi_pend = 0; m_hi_q = 0;
      m_nmi_pend = 0; m_nmi_q = 0; e_valid = 0; e_ext = 0; e_src = 0; e_vec = 0;
      e_stat = 8'h07;
    end else begin
      r_nmi = m_nmi_pend & nmi_req;
      r_hi  = m_hi_pend & !m_mask[2] & m_gie;
      r_mid = vec_mid_req & !m_mask[1] & m_gie;
      r_lo  = vec_low_req & !m_mask[0] & m_gie;
      r_ex  = ext_req & m_gie;
      a_nmi = irq_ack & e_valid & e_src[4];
      a_hi  = irq_ack & e_valid & e_src[3];
      a_m   = irq_ack & e_valid & (e_src[3:0] != 0);
      e_stat = {ser_in, m_hi_pend, vec_mid_req, vec_low_req, m_gie, m_mask};
      e_valid = 1; e_ext = 0;
      if (irq_ack)    begin e_valid = 0; e_src = 0;       e_vec = 0; end
      else if (r_nmi) begin e_src = 5'b10000; e_vec = 16'h0024; end
      else if (r_hi)  begin e_src = 5'b01000; e_vec = 16'h003C; end
      else if (r_mid) begin e_src = 5'b00100; e_vec = 16'h0034; end
      else if (r_lo)  begin e_src = 5'b00010; e_vec = 16'h002C; end
      else if (r_ex)  begin e_src = 5'b00001; e_vec = 16'h0000; e_ext = 1; end
      else            begin e_valid = 0; e_src = 0; e_vec = 0; end
      edge_hi  = vec_edge_req & !m_hi_q;
      edge_nmi = nmi_req & !m_nmi_q;
      m_hi_pend  = edge_hi | (m_hi_pend & !(ctl_wr & ctl_data[4]) & !a_hi);
      m_nmi_pend = nmi_req ? (edge_nmi | (m_nmi_pend & !a_nmi)) : 1'b0;
      m_hi_q = vec_edge_req; m_nmi_q = nmi_req;
      if (ctl_wr && ctl_data[3]) m_mask = ctl_data[2:0];
      if (ctl_wr && ctl_data[6]) m_ser  = ctl_data[7];
      if (ie_clr || a_m) m_gie = 0; else if (ie_set) m_gie = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R13: per-cycle comparison of every output against the model
  always @(negedge clk) begin
    if (cmp_on)
      chk("R13 model", {irq_valid, irq_src, irq_vector, irq_ext, stat_data, ser_out},
          {e_valid, e_src, e_vec, e_ext, e_stat, m_ser});
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic [7:0] d);
    ctl_wr = 1; ctl_data = d; tick(1); ctl_wr = 0; ctl_data = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(3); cmp_on = 1; rst = 0; tick(1);
    chk("R1 stat", stat_data, 8'h07);
    chk("R1 valid", irq_valid, 0);
    chk("R1 ser_out", ser_out, 0);

    ctl(8'h0A); tick(1); chk("R6 mask 0x0A", stat_data[2:0], 3'b010);
    ctl(8'h05); tick(1); chk("R6 mask_en low", stat_data[2:0], 3'b010);

    ie_set = 1; tick(1); ie_set = 0; tick(1); chk("R12 set", stat_data[3], 1);
    ie_set = 1; ie_clr = 1; tick(1); ie_set = 0; ie_clr = 0; tick(1);
    chk("R12 clear wins", stat_data[3], 0);
    ie_set = 1; tick(1); ie_set = 0; tick(1); chk("R12 set again", stat_data[3], 1);

    vec_low_req = 1; tick(1);
    chk("R3 low src", irq_src, 5'b00010); chk("R3 low vec", irq_vector, 16'h002C);
    vec_mid_req = 1; tick(1); chk("R5 mid masked", irq_src, 5'b00010);
    vec_edge_req = 1; tick(1); vec_edge_req = 0; tick(1);
    chk("R10 edge remembered", irq_src, 5'b01000); chk("R3 edge vec", irq_vector, 16'h003C);
    nmi_req = 1; tick(2);
    chk("R2 nmi wins", irq_src, 5'b10000); chk("R3 nmi vec", irq_vector, 16'h0024);
    nmi_req = 0; tick(1); chk("R4 nmi dropped", irq_src, 5'b01000);

    irq_ack = 1; tick(1); irq_ack = 0; chk("R13 ack gap", irq_valid, 0);
    tick(1);
    chk("R11 edge pend cleared", stat_data[6], 0);
    chk("R11 enable cleared", stat_data[3], 0);
    chk("R9 status layout", stat_data, 8'h32);
    chk("R5 disabled quiet", irq_valid, 0);

    vec_low_req = 0; vec_mid_req = 0; ext_req = 1; ie_set = 1; tick(1); ie_set = 0; tick(1);
    chk("R3 ext flag", irq_ext, 1); chk("R3 ext vec", irq_vector, 0);
    chk("R2 ext src", irq_src, 5'b00001);
    ext_req = 0; ie_clr = 1; tick(1); ie_clr = 0;

    vec_edge_req = 1; tick(1); vec_edge_req = 0; tick(1);
    chk("R10 edge pending", stat_data[6], 1);
    ctl(8'h30); tick(1);
    chk("R7 pend cleared", stat_data[6], 0); chk("R7 masks kept", stat_data[2:0], 3'b010);

    ctl_wr = 1; ctl_data = 8'h80; tick(1); chk("R8 gated", ser_out, 0);
    ctl_data = 8'hC0; tick(1); chk("R8 driven", ser_out, 1);
    ctl_wr = 0; ctl_data = 0;
    ser_in = 1; tick(1); chk("R9 ser_in bit", stat_data[7], 1); ser_in = 0;

    ctl(8'h0F); nmi_req = 1; tick(2);
    chk("R4 nmi unmaskable", irq_src, 5'b10000);
    irq_ack = 1; tick(1); irq_ack = 0; chk("R13 nmi ack gap", irq_valid, 0);
    tick(1); chk("R11 nmi not repeated", irq_valid, 0);
    nmi_req = 0;

    ctl(8'h08); ie_set = 1; tick(1); ie_set = 0;
    vec_mid_req = 1; tick(1);
    chk("R10 mid level", irq_src, 5'b00100); chk("R3 mid vec", irq_vector, 16'h0034);
    vec_low_req = 1; tick(1); chk("R2 mid over low", irq_src, 5'b00100);
    vec_mid_req = 0; vec_low_req = 0; tick(1); tick(1);
    chk("R10 level gone", irq_valid, 0);

    for (int k = 0; k < 2000; k++) begin
      nmi_req      = ($urandom % 6 == 0) ? ~nmi_req : nmi_req;
      vec_edge_req = ($urandom % 3 == 0);
      vec_mid_req  = ($urandom % 4 == 0);
      vec_low_req  = ($urandom % 4 == 0);
      ext_req      = ($urandom % 3 == 0);
      ser_in       = $urandom % 2;
      ctl_wr       = ($urandom % 8 == 0);
      ctl_data     = 8'($urandom);
      ie_set       = ($urandom % 4 == 0);
      ie_clr       = ($urandom % 10 == 0);
      irq_ack      = irq_valid && ($urandom % 3 == 0);
      tick(1);
    end
    summary();
    $finish;
  end
endmodule